// File: doc/BRIEF.md
# Hashed-Digest Set-Associative Flow Cache

This block remembers forwarding decisions for network flows so that most packets skip the slow full classifier. It does not store the 104-bit flow key. It keeps a 32-bit digest of the key together with a short route code. Two independent CRC hashes are taken from the key. One picks a set of the cache. The other gives the digest, which is compared against every way of that set in the same cycle. If two flows share both set and digest, a false hit can occur. The chance of this is about WAYS/2^DIG_W per lookup, so a wider digest is needed as associativity grows.

A lookup is accepted with a valid/ready handshake. One cycle later the block returns a registered response: a hit flag and, on a hit, the stored route. On a miss the requester passes the flow to the external classifier. The classifier later writes the result back through the insert port. An insert takes priority over a lookup in the same cycle. A lookup marked as a connection-opening packet always reports a miss, so a new flow is never given a stale or colliding decision. Replacement inside a set is true least-recently-used.

Top module: `digest_cache`

## Requirements
- R1: After reset no way holds a valid entry. Every lookup misses and `lk_ready_o` is high while no insert is presented.
- R2: Both hashes are MSB-first bitwise CRC-32 over key bits 103 down to 0. The register starts at 0xFFFFFFFF and shifts left. It is XORed with the polynomial when (reg[31] XOR key bit) is 1. There is no final inversion. The digest uses polynomial 0x04C11DB7. The set index is the CRC with polynomial 0x1EDC6F41, modulo SETS. A lookup of an inserted flow hits and returns its route. A miss returns route 0.
- R3: A lookup with `lk_new_flow_i` high reports a miss with route 0. It leaves the contents and the replacement order of the set unchanged.
- R4: An insert fills the lowest-numbered invalid way of its set first. WAYS distinct flows in one set are all kept.
- R5: In a full set, an insert of a new digest evicts the least-recently-used way. Hits and inserts both make a way most-recently-used.
- R6: While `ins_valid_i` is high, `lk_ready_o` is low. The insert is performed and no lookup is accepted in that cycle.
- R7: An insert whose digest is already valid in its set overwrites that way's route. It does not allocate a second way.
- R8: `rsp_valid_o` is high for exactly the one cycle after each accepted lookup and low otherwise.
- R9: Inserts and lookups touch only the selected set. Entries in other sets are never evicted or changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup accepted this cycle |
| lk_key_i | input | KEY_W | Flow key to look up |
| lk_new_flow_i | input | 1 | Connection-opening packet, force a miss |
| ins_valid_i | input | 1 | Insert request valid |
| ins_ready_o | output | 1 | Insert accepted (always high) |
| ins_key_i | input | KEY_W | Flow key to insert |
| ins_route_i | input | ROUTE_W | Route to store for the flow |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_route_o | output | ROUTE_W | Route on a hit, zero on a miss |

## Verification
The bench builds the cache with SETS=4 and the default four ways. The bench computes both CRCs itself, so it can pick keys that land in a chosen set. All sixteen ways can then be filled and read back one by one. Because every set is full, eviction order, in-place route updates and the isolation between sets can all be seen directly at the response port. The forced-miss hint is checked for both its result and its lack of effect on LRU order. The insert-over-lookup collision is also exercised.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam logic [31:0] DIGEST_POLY = 32'h04C11DB7;
  localparam logic [31:0] INDEX_POLY  = 32'h1EDC6F41;
  localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
endpackage

// File: rtl/dc_hash.sv
module dc_hash #(
  parameter int unsigned IN_W  = 104,
  parameter int unsigned OUT_W = 32,
  parameter logic [31:0] POLY  = 32'h04C11DB7,
  parameter logic [31:0] SEED  = 32'hFFFFFFFF
) (
  input  logic [IN_W-1:0]  data_i,
  output logic [OUT_W-1:0] hash_o
);
  logic [31:0] crc;
  logic        fb;

  always_comb begin
    crc = SEED;
    fb  = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb  = crc[31] ^ data_i[i];
      crc = {crc[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    hash_o = crc[OUT_W-1:0];
  end
endmodule

// File: rtl/dc_set_store.sv
module dc_set_store #(
  parameter int unsigned SETS    = 64,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned DIG_W   = 32,
  parameter int unsigned ROUTE_W = 4,
  localparam int unsigned SET_W  = $clog2(SETS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SET_W-1:0]                 set_i,
  output logic [WAYS-1:0]                  valid_o,
  output logic [WAYS-1:0][DIG_W-1:0]       dig_o,
  output logic [WAYS-1:0][ROUTE_W-1:0]     route_o,
  input  logic                             we_i,
  input  logic [WAYS-1:0]                  way_oh_i,
  input  logic [DIG_W-1:0]                 wdig_i,
  input  logic [ROUTE_W-1:0]               wroute_i
);
  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAYS-1:0][DIG_W-1:0]   dig_q   [SETS];
  logic [WAYS-1:0][ROUTE_W-1:0] route_q [SETS];

  assign valid_o = valid_q[set_i];
  assign dig_o   = dig_q[set_i];
  assign route_o = route_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(SETS); s++) begin
        valid_q[s] <= '0;
        dig_q[s]   <= '0;
        route_q[s] <= '0;
      end
    end else if (we_i) begin
      for (int w = 0; w < int'(WAYS); w++) begin
        if (way_oh_i[w]) begin
          valid_q[set_i][w] <= 1'b1;
          dig_q[set_i][w]   <= wdig_i;
          route_q[set_i][w] <= wroute_i;
        end
      end
    end
  end
endmodule

// File: rtl/dc_match.sv
module dc_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned DIG_W = 32
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][DIG_W-1:0] dig_row_i,
  input  logic [DIG_W-1:0]           dig_i,
  output logic [WAYS-1:0]            match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (dig_row_i[w] == dig_i);
  end
endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  // rank 0 = most recent, WAYS-1 = least recent; ranks form a permutation
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            oldest_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(SETS); s++)
        for (int w = 0; w < int'(WAYS); w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < int'(WAYS); w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      oldest_oh[w] = (age_q[set_i][w] == WAY_W'(WAYS - 1));
      if (oldest_oh[w]) victim_o = WAY_W'(w);
    end
  end

  p_one_oldest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_oh) == 1);
endmodule

// File: rtl/digest_cache.sv
module digest_cache
  import dc_pkg::*;
#(
  parameter int unsigned KEY_W   = 104,
  parameter int unsigned DIG_W   = 32,
  parameter int unsigned ROUTE_W = 4,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned SETS    = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  output logic               lk_ready_o,
  input  logic [KEY_W-1:0]   lk_key_i,
  input  logic               lk_new_flow_i,
  input  logic               ins_valid_i,
  output logic               ins_ready_o,
  input  logic [KEY_W-1:0]   ins_key_i,
  input  logic [ROUTE_W-1:0] ins_route_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [ROUTE_W-1:0] rsp_route_o
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic                         op_ins, op_lk;
  logic [KEY_W-1:0]             key;
  logic [DIG_W-1:0]             dig;
  logic [SET_W-1:0]             set_idx;
  logic [WAYS-1:0]              valid_row, match_vec;
  logic [WAYS-1:0][DIG_W-1:0]   dig_row;
  logic [WAYS-1:0][ROUTE_W-1:0] route_row;
  logic                         hit_any, free_any, lk_hit;
  logic [WAY_W-1:0]             hit_way, free_way, victim, tgt_way, touch_way;
  logic [WAYS-1:0]              tgt_oh;
  logic                         touch;
  logic                         rsp_valid_q, rsp_hit_q;
  logic [ROUTE_W-1:0]           rsp_route_q;

  // insert wins the single access slot
  assign op_ins      = ins_valid_i;
  assign op_lk       = lk_valid_i && !ins_valid_i;
  assign lk_ready_o  = !ins_valid_i;
  assign ins_ready_o = 1'b1;
  assign key         = op_ins ? ins_key_i : lk_key_i;

  dc_hash #(.IN_W(KEY_W), .OUT_W(DIG_W), .POLY(DIGEST_POLY), .SEED(CRC_SEED))
    u_dig_hash (.data_i(key), .hash_o(dig));

  dc_hash #(.IN_W(KEY_W), .OUT_W(SET_W), .POLY(INDEX_POLY), .SEED(CRC_SEED))
    u_idx_hash (.data_i(key), .hash_o(set_idx));

  dc_set_store #(.SETS(SETS), .WAYS(WAYS), .DIG_W(DIG_W), .ROUTE_W(ROUTE_W)) u_store (
    .clk_i, .rst_ni,
    .set_i    (set_idx),
    .valid_o  (valid_row),
    .dig_o    (dig_row),
    .route_o  (route_row),
    .we_i     (op_ins),
    .way_oh_i (tgt_oh),
    .wdig_i   (dig),
    .wroute_i (ins_route_i)
  );

  dc_match #(.WAYS(WAYS), .DIG_W(DIG_W)) u_match (
    .valid_i   (valid_row),
    .dig_row_i (dig_row),
    .dig_i     (dig),
    .match_o   (match_vec)
  );

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < int'(WAYS); w++)
      if (match_vec[w]) hit_way = WAY_W'(w);
    for (int w = int'(WAYS) - 1; w >= 0; w--)
      if (!valid_row[w]) free_way = WAY_W'(w);
  end

  assign hit_any  = |match_vec;
  assign free_any = !(&valid_row);
  assign tgt_way  = hit_any ? hit_way : (free_any ? free_way : victim);

  for (genvar w = 0; w < WAYS; w++) begin : g_oh
    assign tgt_oh[w] = (tgt_way == WAY_W'(w));
  end

  assign lk_hit    = op_lk && hit_any && !lk_new_flow_i;
  assign touch     = op_ins || lk_hit;
  assign touch_way = op_ins ? tgt_way : hit_way;

  dc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i, .rst_ni,
    .set_i       (set_idx),
    .touch_i     (touch),
    .touch_way_i (touch_way),
    .victim_o    (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_route_q <= '0;
    end else begin
      rsp_valid_q <= op_lk;
      rsp_hit_q   <= lk_hit;
      rsp_route_q <= lk_hit ? route_row[hit_way] : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_route_o = rsp_route_q;

  p_rsp_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_ready_o) |=> rsp_valid_o);
  p_rsp_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_valid_i && lk_ready_o) |=> !rsp_valid_o);
  p_ins_priority_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i |-> !lk_ready_o);
  p_new_flow_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_ready_o && lk_new_flow_i) |=> !rsp_hit_o);
  p_miss_route_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_route_o == '0));
  p_hit_has_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);
  p_single_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));
endmodule

// File: tb/tb_digest_cache.sv
module tb_digest_cache;
  localparam int SETS = 4;
  localparam int WAYS = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         lk_valid_i = 1'b0, lk_new_flow_i = 1'b0;
  logic [103:0] lk_key_i = '0, ins_key_i = '0;
  logic         ins_valid_i = 1'b0;
  logic [3:0]   ins_route_i = '0;
  logic         lk_ready_o, ins_ready_o, rsp_valid_o, rsp_hit_o;
  logic [3:0]   rsp_route_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #10ns clk_i = ~clk_i;

  digest_cache #(.SETS(SETS), .WAYS(WAYS)) dut (
    .clk_i, .rst_ni, .lk_valid_i, .lk_ready_o, .lk_key_i, .lk_new_flow_i,
    .ins_valid_i, .ins_ready_o, .ins_key_i, .ins_route_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_route_o
  );

  function automatic logic [31:0] crc(input logic [103:0] k, input logic [31:0] poly);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 103; i >= 0; i--) begin
      logic fb = r[31] ^ k[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  function automatic logic [103:0] mk_key(input int i);
    return {72'h5a_3c_99_00_11_22_33_44_55, 32'(i * 7 + 3)};
  endfunction

  // nth key (0-based) whose set index is s
  function automatic logic [103:0] key_in_set(input int s, input int nth);
    int found = 0;
    for (int i = 0; i < 100000; i++) begin
      logic [103:0] k = mk_key(i);
      if (int'(crc(k, 32'h1EDC6F41) % SETS) == s) begin
        if (found == nth) return k;
        found++;
      end
    end
    return '0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_insert(input logic [103:0] k, input logic [3:0] r);
    @(negedge clk_i);
    ins_valid_i = 1'b1; ins_key_i = k; ins_route_i = r;
    @(negedge clk_i);
    ins_valid_i = 1'b0;
  endtask

  task automatic do_lookup(input logic [103:0] k, input bit nf,
                           output bit hit, output logic [3:0] route);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_key_i = k; lk_new_flow_i = nf;
    @(negedge clk_i);
    check(rsp_valid_o === 1'b1, "R8 rsp_valid after accept", int'(rsp_valid_o), 1);
    hit = rsp_hit_o; route = rsp_route_o;
    lk_valid_i = 1'b0; lk_new_flow_i = 1'b0;
  endtask

  task automatic expect_hit(input logic [103:0] k, input logic [3:0] r, input string req);
    bit h; logic [3:0] rt;
    do_lookup(k, 1'b0, h, rt);
    check(h == 1'b1, {req, " hit"}, int'(h), 1);
    check(rt == r, {req, " route"}, int'(rt), int'(r));
  endtask

  task automatic expect_miss(input logic [103:0] k, input bit nf, input string req);
    bit h; logic [3:0] rt;
    do_lookup(k, nf, h, rt);
    check(h == 1'b0, {req, " miss"}, int'(h), 0);
    check(rt == 4'd0, {req, " miss route zero"}, int'(rt), 0);
  endtask

  initial begin
    #(20ns * 150000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [103:0] kt [SETS][WAYS];
    logic [103:0] n1, n2;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        kt[s][w] = key_in_set(s, w);
    n1 = key_in_set(1, WAYS);
    n2 = key_in_set(3, WAYS);

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(lk_ready_o === 1'b1, "R1 lk_ready after reset", int'(lk_ready_o), 1);
    check(rsp_valid_o === 1'b0, "R8 rsp_valid idle after reset", int'(rsp_valid_o), 0);
    for (int s = 0; s < SETS; s++) expect_miss(kt[s][0], 1'b0, "R1 empty cache");

    // R8 single-cycle response
    @(negedge clk_i);
    check(rsp_valid_o === 1'b0, "R8 rsp_valid one cycle only", int'(rsp_valid_o), 0);

    // R2/R4/R9 fill every way of every set, then read all back
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        do_insert(kt[s][w], 4'((s * 4 + w + 1) & 15));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        expect_hit(kt[s][w], 4'((s * 4 + w + 1) & 15), "R2 R4 R9 filled set");

    // R3 forced miss on a present flow, entry survives
    expect_miss(kt[0][0], 1'b1, "R3 new-flow hint");
    expect_hit(kt[0][0], 4'd1, "R3 entry kept after hint");

    // R5 set 1 order after reads: LRU w0 .. MRU w3; touch w0 -> LRU w1
    expect_hit(kt[1][0], 4'd5, "R5 promote way0");
    // R3 hint on w1 must not promote it
    expect_miss(kt[1][1], 1'b1, "R3 hint no promote");
    do_insert(n1, 4'd14);
    expect_miss(kt[1][1], 1'b0, "R5 LRU way evicted");
    expect_hit(n1, 4'd14, "R5 new flow stored");
    expect_hit(kt[1][0], 4'd5, "R5 promoted way kept");
    expect_hit(kt[1][2], 4'd7, "R5 way2 kept");
    expect_hit(kt[1][3], 4'd8, "R5 way3 kept");
    for (int w = 0; w < WAYS; w++)
      expect_hit(kt[2][w], 4'((8 + w + 1) & 15), "R9 other set untouched");

    // R7 set 2 order now LRU w0; touch w0 so LRU becomes w1, then re-insert w0
    expect_hit(kt[2][0], 4'd9, "R7 touch");
    do_insert(kt[2][0], 4'd2);
    expect_hit(kt[2][0], 4'd2, "R7 route updated in place");
    expect_hit(kt[2][1], 4'd10, "R7 no second way allocated");
    expect_hit(kt[2][2], 4'd11, "R7 way2 kept");
    expect_hit(kt[2][3], 4'd12, "R7 way3 kept");

    // R6 insert and lookup presented together
    @(negedge clk_i);
    ins_valid_i = 1'b1; ins_key_i = n2; ins_route_i = 4'd5;
    lk_valid_i = 1'b1; lk_key_i = kt[0][1]; lk_new_flow_i = 1'b0;
    #1ns;
    check(lk_ready_o === 1'b0, "R6 lk_ready low during insert", int'(lk_ready_o), 0);
    @(negedge clk_i);
    check(rsp_valid_o === 1'b0, "R6 lookup not accepted", int'(rsp_valid_o), 0);
    ins_valid_i = 1'b0;
    #1ns;
    check(lk_ready_o === 1'b1, "R6 lk_ready back high", int'(lk_ready_o), 1);
    @(negedge clk_i);
    check(rsp_valid_o === 1'b1, "R6 held lookup accepted later", int'(rsp_valid_o), 1);
    check(rsp_hit_o === 1'b1 && rsp_route_o == 4'd2, "R6 held lookup result",
          int'(rsp_route_o), 2);
    lk_valid_i = 1'b0;
    expect_hit(n2, 4'd5, "R6 insert performed");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule